// File: doc/BRIEF.md
# Tunable IIR Coefficient Calculator

This block converts a 12-bit cutoff word into the three 12-bit signed fixed-point coefficients (11 fractional bits, scaled by 2048) that a time-multiplexed low-pass IIR datapath needs. It also produces a 4-bit one-hot band code that tells that datapath how many sections to use. There is no coefficient table and no general multiplier. The word is sorted into one of four octave bands, a 9-bit mantissa is taken from it, and each coefficient comes from shifts and constant additions or subtractions applied to that mantissa.

A new cutoff word is taken in only on clock edges where the load strobe is high. Between loads the outputs keep their values. The band code is decoded from the held word without a register. The loop and cross coefficients are registered one edge after the word changes. The gain coefficient is computed from the registered loop coefficient, so it settles one edge after that.

The external reset is asynchronous and active-low. Asserting it takes effect at once. Its release passes through a two-stage synchronizer before it reaches the registers.

Top module: `iir_coef_tuner`

## Requirements
- R1: The held cutoff word takes the value on `cutoff_word` only at rising edges where `cutoff_load` is 1. If `cutoff_load` is 1 on several edges in a row, the last captured word wins. While `cutoff_load` is 0, changes on `cutoff_word` have no effect on any output.
- R2: While `rst_n` is low, the held word and all three coefficient registers are zero, so `band_oh` reads 4'b1000. This takes effect without waiting for a clock edge.
- R3: `band_oh` is one-hot with fixed priority on the held word W. It is 4'b0001 if W[11] or W[10] is set, else 4'b0010 if W[9] is set, else 4'b0100 if W[8] is set, else 4'b1000.
- R4: The mantissa M is W[11:3] for band 4'b0001, W[10:2] for 4'b0010, W[9:1] for 4'b0100, and W[8:0] for 4'b1000.
- R5: `coef_cross` is registered as (0x440 − M) modulo 4096.
- R6: A 10-bit signed intermediate V is formed as (M − K) modulo 1024, where K = 226 in band 4'b0001 and K = 240 in every other band. `coef_loop` is registered as (11·V + 1) modulo 4096.
- R7: `coef_gain` is registered as (40 − (L>>>2) − (L>>>3) − (L>>>5)) modulo 4096. Here L is the registered `coef_loop` read as a signed 12-bit value, and >>> is an arithmetic shift.
- R8: Timing after a load edge E. `band_oh` is updated right after E. `coef_cross` and `coef_loop` still hold their old values right after E and change at E+1. `coef_gain` still holds its old value right after E+1 and changes at E+2.
- R9: After `rst_n` rises, the coefficients stay zero through the first two rising edges. At the third edge, `coef_cross` and `coef_loop` take the values for a held word of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| cutoff_load | input | 1 | Capture strobe for the cutoff word |
| cutoff_word | input | 12 | Cutoff-frequency word |
| coef_gain | output | 12 | Gain coefficient, signed, 11 fractional bits |
| coef_loop | output | 12 | Loop coefficient, signed, 11 fractional bits |
| coef_cross | output | 12 | Cross coefficient, signed, 11 fractional bits |
| band_oh | output | 4 | One-hot band code |

## Verification
The assertions check these properties on every cycle:
- The held word follows the load strobe: it captures when the strobe is high and holds when it is low.
- The band code stays one-hot.
- The default band appears only when the top four bits of the held word are clear.
- Each coefficient register stays constant whenever its source has been steady.

The exact wrapped arithmetic values of the three coefficients, the 226/240 offset switch at the band boundary, and the edge-by-edge settling order can only be shown by the bench scenarios. The same applies to the reset release delay and the async clear in the middle of a run.

// File: rtl/tun_pkg.sv
package tun_pkg;
  localparam int WORD_W = 12;
  localparam int MANT_W = 9;
  localparam int BANDS  = 4;
  localparam int COEF_W = 12;
  localparam int MID_W  = MANT_W + 1;

  localparam logic [COEF_W-1:0] CROSS_BASE = COEF_W'(12'h440);
  localparam logic [COEF_W-1:0] GAIN_BASE  = COEF_W'(40);
  localparam logic [MID_W-1:0]  OFS_TOP    = MID_W'(226);
  localparam logic [MID_W-1:0]  OFS_REST   = MID_W'(240);

  localparam int LOOP_SH_A = 3;
  localparam int LOOP_SH_B = 1;
  localparam int GAIN_SH_A = 2;
  localparam int GAIN_SH_B = 3;
  localparam int GAIN_SH_C = 5;
endpackage

// File: rtl/tun_rst_sync.sv
module tun_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/tun_cutoff_reg.sv
module tun_cutoff_reg #(
  parameter int WORD_W = tun_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_q
);
  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (load_en) word_d = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (word_q == $past(word_in)));

  // R1
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(word_q));
endmodule

// File: rtl/tun_band_norm.sv
module tun_band_norm #(
  parameter int WORD_W = tun_pkg::WORD_W,
  parameter int MANT_W = tun_pkg::MANT_W,
  parameter int BANDS  = tun_pkg::BANDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_q,
  output logic [BANDS-1:0]  band_oh,
  output logic [MANT_W-1:0] mant,
  output logic              top_band
);
  // The top band covers two word bits; each middle band is keyed on one bit.
  logic [BANDS-1:0]  hit;
  logic [MANT_W-1:0] slice [BANDS];

  assign hit[0]       = |word_q[WORD_W-1:WORD_W-2];
  assign hit[BANDS-1] = 1'b1;

  for (genvar r = 1; r < BANDS-1; r++) begin : g_mid_hit
    assign hit[r] = word_q[WORD_W-2-r];
  end

  for (genvar r = 0; r < BANDS; r++) begin : g_slice
    assign slice[r] = word_q[(BANDS-1-r) +: MANT_W];
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    band_oh = '0;
    for (int r = 0; r < BANDS; r++) begin
      if (!found && hit[r]) begin
        band_oh[r] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    mant = '0;
    for (int r = 0; r < BANDS; r++) begin
      if (band_oh[r]) mant = mant | slice[r];
    end
  end

  assign top_band = band_oh[0];

  // R3
  band_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(band_oh));

  // R3
  band_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    band_oh[BANDS-1] |-> (word_q[WORD_W-1:WORD_W-BANDS] == '0));
endmodule

// File: rtl/tun_coef_arith.sv
module tun_coef_arith
  import tun_pkg::*;
#(
  parameter int MANT_W = tun_pkg::MANT_W,
  parameter int COEF_W = tun_pkg::COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W-1:0] mant,
  input  logic              top_band,
  output logic [COEF_W-1:0] gain_q,
  output logic [COEF_W-1:0] loop_q,
  output logic [COEF_W-1:0] cross_q
);
  localparam int M1_W = MANT_W + 1;

  logic signed [M1_W-1:0]   mid;
  logic signed [COEF_W-1:0] mid_ext;
  logic signed [COEF_W-1:0] loop_s;
  logic signed [COEF_W-1:0] tap_sum;
  logic        [COEF_W-1:0] loop_d;
  logic        [COEF_W-1:0] cross_d;
  logic        [COEF_W-1:0] gain_d;

  // Loop and cross coefficients: straight from the mantissa.
  always_comb begin
    mid     = $signed({1'b0, mant} - (top_band ? OFS_TOP : OFS_REST));
    mid_ext = COEF_W'(mid);
    loop_d  = COEF_W'(mid_ext <<< LOOP_SH_A)
            + {mid_ext[COEF_W-1-LOOP_SH_B:0], 1'b1}
            + mid_ext;
    cross_d = CROSS_BASE - COEF_W'(mant);
  end

  // Gain coefficient: second stage, fed by the registered loop value.
  always_comb begin
    loop_s  = $signed(loop_q);
    tap_sum = (loop_s >>> GAIN_SH_A) + (loop_s >>> GAIN_SH_B) + (loop_s >>> GAIN_SH_C);
    gain_d  = GAIN_BASE - tap_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q  <= '0;
      cross_q <= '0;
      gain_q  <= '0;
    end else begin
      loop_q  <= loop_d;
      cross_q <= cross_d;
      gain_q  <= gain_d;
    end
  end

  // R5 R6
  first_stage_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(mant) && $stable(top_band)) |=> ($stable(cross_q) && $stable(loop_q)));

  // R7
  gain_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(loop_q)) |=> $stable(gain_q));
endmodule

// File: rtl/iir_coef_tuner.sv
module iir_coef_tuner #(
  parameter int WORD_W = tun_pkg::WORD_W,
  parameter int MANT_W = tun_pkg::MANT_W,
  parameter int BANDS  = tun_pkg::BANDS,
  parameter int COEF_W = tun_pkg::COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cutoff_load,
  input  logic [WORD_W-1:0] cutoff_word,
  output logic [COEF_W-1:0] coef_gain,
  output logic [COEF_W-1:0] coef_loop,
  output logic [COEF_W-1:0] coef_cross,
  output logic [BANDS-1:0]  band_oh
);
  logic              rst_i_n;
  logic [WORD_W-1:0] word_q;
  logic [MANT_W-1:0] mant;
  logic              top_band;

  tun_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tun_cutoff_reg #(.WORD_W(WORD_W)) u_word (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .load_en (cutoff_load),
    .word_in (cutoff_word),
    .word_q  (word_q)
  );

  tun_band_norm #(.WORD_W(WORD_W), .MANT_W(MANT_W), .BANDS(BANDS)) u_band (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .word_q   (word_q),
    .band_oh  (band_oh),
    .mant     (mant),
    .top_band (top_band)
  );

  tun_coef_arith #(.MANT_W(MANT_W), .COEF_W(COEF_W)) u_arith (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .mant     (mant),
    .top_band (top_band),
    .gain_q   (coef_gain),
    .loop_q   (coef_loop),
    .cross_q  (coef_cross)
  );
endmodule

// File: tb/tb_iir_coef_tuner.sv
`timescale 1ns/1ps
module tb_iir_coef_tuner;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cutoff_load;
  logic [11:0] cutoff_word;
  logic [11:0] coef_gain, coef_loop, coef_cross;
  logic [3:0]  band_oh;

  int checks = 0;
  int fails  = 0;
  int prev_cross, prev_loop, prev_gain;

  always #2 clk = ~clk;

  iir_coef_tuner dut (
    .clk(clk), .rst_n(rst_n), .cutoff_load(cutoff_load), .cutoff_word(cutoff_word),
    .coef_gain(coef_gain), .coef_loop(coef_loop), .coef_cross(coef_cross), .band_oh(band_oh)
  );

  // {word[11:0], expected band[3:0]}
  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    {12'h000, 4'b1000}, {12'h0FF, 4'b1000}, {12'h100, 4'b0100}, {12'h1FF, 4'b0100},
    {12'h200, 4'b0010}, {12'h3FF, 4'b0010}, {12'h400, 4'b0001}, {12'h7FF, 4'b0001},
    {12'h800, 4'b0001}, {12'hFFF, 4'b0001}, {12'h155, 4'b0100}, {12'h2AA, 4'b0010},
    {12'h0A5, 4'b1000}, {12'hC3C, 4'b0001}
  };

  function automatic int band_of(int w);
    if (w[11] || w[10]) return 1;
    if (w[9]) return 2;
    if (w[8]) return 4;
    return 8;
  endfunction

  function automatic int mant_of(int w);
    int b = band_of(w);
    int sh = (b == 1) ? 3 : (b == 2) ? 2 : (b == 4) ? 1 : 0;
    return (w >> sh) & 511;
  endfunction

  function automatic int cross_of(int w);
    return (1088 - mant_of(w)) & 4095;
  endfunction

  function automatic int loop_of(int w);
    int off = (band_of(w) == 1) ? 226 : 240;
    int v = (mant_of(w) - off) & 1023;
    if (v >= 512) v = v - 1024;
    return (11 * v + 1) & 4095;
  endfunction

  function automatic int gain_of(int loop_val);
    int s = (loop_val >= 2048) ? loop_val - 4096 : loop_val;
    int sum = (s >>> 2) + (s >>> 3) + (s >>> 5);
    return (40 - sum) & 4095;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reset_cycle();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R2 cross cleared", int'(coef_cross), 0);
    chk("R2 loop cleared", int'(coef_loop), 0);
    chk("R2 gain cleared", int'(coef_gain), 0);
    chk("R2 band default", int'(band_oh), 8);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 cross zero edge1", int'(coef_cross), 0);
    @(negedge clk);
    chk("R9 loop zero edge2", int'(coef_loop), 0);
    @(negedge clk);
    chk("R9 cross edge3", int'(coef_cross), cross_of(0));
    chk("R9 loop edge3", int'(coef_loop), loop_of(0));
    @(negedge clk);
    chk("R7 gain after reset", int'(coef_gain), gain_of(loop_of(0)));
    prev_cross = cross_of(0);
    prev_loop  = loop_of(0);
    prev_gain  = gain_of(loop_of(0));
  endtask

  task automatic load_and_check(input int w, input int eb);
    @(negedge clk);
    cutoff_load = 1'b1;
    cutoff_word = 12'(w);
    @(negedge clk);
    cutoff_load = 1'b0;
    cutoff_word = ~12'(w);
    chk("R3 band", int'(band_oh), eb);
    chk("R8 cross not yet", int'(coef_cross), prev_cross);
    @(negedge clk);
    chk("R5 R4 cross", int'(coef_cross), cross_of(w));
    chk("R6 loop", int'(coef_loop), loop_of(w));
    chk("R8 gain not yet", int'(coef_gain), prev_gain);
    @(negedge clk);
    chk("R7 gain", int'(coef_gain), gain_of(loop_of(w)));
    prev_cross = cross_of(w);
    prev_loop  = loop_of(w);
    prev_gain  = gain_of(loop_of(w));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cutoff_load = 1'b0;
    cutoff_word = 12'h000;
    reset_cycle();

    for (int i = 0; i < NV; i++) begin
      load_and_check(int'(VEC[i][15:4]), int'(VEC[i][3:0]));
    end

    // R1: word changes with the strobe low leave every output unchanged
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      cutoff_word = 12'((k * 397 + 91) & 4095);
      @(negedge clk);
      chk("R1 hold cross", int'(coef_cross), prev_cross);
      chk("R1 hold loop", int'(coef_loop), prev_loop);
      chk("R1 hold gain", int'(coef_gain), prev_gain);
      chk("R1 hold band", int'(band_oh), band_of(int'(VEC[NV-1][15:4])));
    end

    // R1: back-to-back loads, the last word wins
    @(negedge clk);
    cutoff_load = 1'b1;
    cutoff_word = 12'h7A0;
    @(negedge clk);
    cutoff_word = 12'h123;
    @(negedge clk);
    cutoff_load = 1'b0;
    cutoff_word = 12'hFFF;
    repeat (2) @(negedge clk);
    chk("R1 last load band", int'(band_oh), band_of('h123));
    chk("R1 last load cross", int'(coef_cross), cross_of('h123));
    chk("R1 last load gain", int'(coef_gain), gain_of(loop_of('h123)));

    // R2 R9: asynchronous reset in the middle of a run
    reset_cycle();
    load_and_check('h3C0, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule